// File: doc/BRIEF.md
# Steerable Interrupt Routing Controller

This block gathers twelve level-sensitive interrupt requests and routes each of them to one of four processor interrupt lines. A programmable 2-bit selector per source decides the line, so software can move a source to another line without rewiring. Eight of the sources come from on-board devices: the bus controller, floppy, keyboard, two serial ports, the parallel port, general-purpose I/O and the real-time clock. The other four are PCI interrupt lines. Each group of sources has its own enable mask. A source reaches its line only while its enable bit is set and its input is high.

A separate error path latches three system events: bus error, power failure and the debug switch. These events drive their own processor interrupt line, which is independent of the steering. Software clears the latched error bits by writing ones to them.

Access is through a small register port. It has a 4-bit word address, a one-cycle write strobe, 32-bit write data and combinational read data. Address 0 is the device group: a write sets its enable mask and a read returns its raw input levels. Address 1 holds the error bits. Address 2 is the PCI group and behaves like address 0. Addresses 3 to 5 are the steering registers.

Top module: `irq_route_top`

## Requirements
- R1: After reset, both enable masks, all steering fields and all error bits are zero. cpuIrq and errIrq are low, and a read of every address returns zero while all inputs are low.
- R2: A write to address 0 loads the device enable mask from wdata[7:0]. A write to address 2 loads the PCI enable mask from wdata[3:0]. A read of address 0 returns devIrq in bits [7:0], and a read of address 2 returns pciIrq in bits [3:0]. These reads show the raw input levels whatever the enable masks hold, and every other bit reads as zero.
- R3: Addresses 3, 4 and 5 are steering registers 0, 1 and 2. Each is 8 bits wide and reads back what was written. Each register holds four 2-bit fields at bits [1:0], [3:2], [5:4] and [7:6]. Register 0 steers devIrq[0..3] (controller, floppy, keyboard, serial 1). Register 1 steers devIrq[4..7] (serial 2, parallel, GPIO, clock). Register 2 steers pciIrq[0..3]. In each register the lowest field belongs to the lowest-numbered source.
- R4: cpuIrq[n] is high in the same cycle whenever at least one source is enabled, asserted and has a steering field equal to n. Otherwise cpuIrq[n] is low.
- R5: A source whose enable bit is clear has no effect on cpuIrq.
- R6: Error bit 0 (bus error), bit 1 (power failure) and bit 2 (debug switch) each set on a rising edge of errEvt[0], errEvt[1] and errEvt[2]. A set bit stays set after its event drops. The bits read at address 1 in bits [2:0].
- R7: A write to address 1 clears each error bit whose wdata bit is one and leaves the other error bits as they are. If a clear and a rising edge of the same event fall in the same cycle, the bit ends up set.
- R8: errIrq is high exactly when at least one error bit is set. Enable masks and steering have no effect on it.
- R9: Writes to addresses 6 to 15 change no state, and reads of those addresses return zero. Reads change no state at any address.
- R10: A write takes effect at the clock edge that samples regWe high. In the cycle before that edge, a read still returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Register word address |
| regWe | input | 1 | Single-cycle write strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data |
| devIrq | input | 8 | On-board device interrupt levels |
| pciIrq | input | 4 | PCI interrupt levels |
| errEvt | input | 3 | Error event inputs: bus error, power failure, debug switch |
| cpuIrq | output | 4 | Steered processor interrupt lines |
| errIrq | output | 1 | Error processor interrupt line |

## Verification
The bench builds the block with its default parameters: four PCI sources, eight device sources and four output lines. With these values all three steering registers are filled and every field value selects a real line. Directed sequences send single sources to each line and test masked sources. They also test clear and capture colliding on the error bits, and writes to unmapped addresses. A long run of random inputs and register writes then exercises combinations of sources sharing a line and clears that race with event edges.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int STEER_FIELDS = 4;
  localparam int MAX_STEER    = 4;
  localparam int STEER_IDX_W  = 2;

  localparam int ADR_DEV    = 0;
  localparam int ADR_ERR    = 1;
  localparam int ADR_PCI    = 2;
  localparam int ADR_STEER0 = 3;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_DEV,
    RD_ERR,
    RD_PCI,
    RD_STEER
  } rdKind_t;

  typedef struct packed {
    logic                   devEnWr;
    logic                   pciEnWr;
    logic                   errClr;
    logic [MAX_STEER-1:0]   steerWr;
    rdKind_t                rdKind;
    logic [STEER_IDX_W-1:0] rdIdx;
  } ctrlStrobes_t;

endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_STEER = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output ctrlStrobes_t      strobes
);

  always_comb begin
    strobes = '0;
    strobes.rdKind = RD_NONE;
    if (int'(regAddr) == ADR_DEV) begin
      strobes.devEnWr = regWe;
      strobes.rdKind  = RD_DEV;
    end else if (int'(regAddr) == ADR_ERR) begin
      strobes.errClr = regWe;
      strobes.rdKind = RD_ERR;
    end else if (int'(regAddr) == ADR_PCI) begin
      strobes.pciEnWr = regWe;
      strobes.rdKind  = RD_PCI;
    end else if (int'(regAddr) >= ADR_STEER0 &&
                 int'(regAddr) < ADR_STEER0 + NUM_STEER) begin
      strobes.rdKind = RD_STEER;
      strobes.rdIdx  = STEER_IDX_W'(int'(regAddr) - ADR_STEER0);
      for (int r = 0; r < NUM_STEER; r++) begin
        if (r == int'(regAddr) - ADR_STEER0) strobes.steerWr[r] = regWe;
      end
    end
  end

  // R9: a write touches at most one register.
  assert_one_target_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.devEnWr, strobes.pciEnWr, strobes.errClr, strobes.steerWr}));

  // R10: no register strobe unless the write strobe is high.
  assert_no_write_without_we_R10: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |-> ({strobes.devEnWr, strobes.pciEnWr, strobes.errClr, strobes.steerWr} == '0));

endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int PCI_SRCS  = 4,
  parameter int DEV_SRCS  = 8,
  parameter int CPU_LINES = 4,
  parameter int ERR_BITS  = 3,
  parameter int DATA_W    = 32,
  parameter int NUM_STEER = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [DATA_W-1:0]    regWdata,
  input  logic [DEV_SRCS-1:0]  devIrq,
  input  logic [PCI_SRCS-1:0]  pciIrq,
  input  logic [ERR_BITS-1:0]  errEvt,
  output logic [DATA_W-1:0]    regRdata,
  output logic [CPU_LINES-1:0] cpuIrq,
  output logic                 errIrq
);

  localparam int NUM_SRC = DEV_SRCS + PCI_SRCS;
  localparam int SEL_W   = (CPU_LINES > 1) ? $clog2(CPU_LINES) : 1;
  localparam int STEER_W = STEER_FIELDS * SEL_W;
  localparam int FLAT_W  = NUM_STEER * STEER_W;

  logic [DEV_SRCS-1:0] devEn;
  logic [PCI_SRCS-1:0] pciEn;
  logic [ERR_BITS-1:0] errBits;
  logic [ERR_BITS-1:0] errPrev;
  logic [ERR_BITS-1:0] errClrMask;
  logic [STEER_W-1:0]  steerReg [NUM_STEER];
  logic [FLAT_W-1:0]   steerFlat;
  logic [NUM_SRC-1:0]  srcAct;
  logic [CPU_LINES-1:0][NUM_SRC-1:0] lineHit;

  // Enable masks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devEn <= '0;
      pciEn <= '0;
    end else begin
      if (strobes.devEnWr) devEn <= regWdata[DEV_SRCS-1:0];
      if (strobes.pciEnWr) pciEn <= regWdata[PCI_SRCS-1:0];
    end
  end

  // Steering registers
  for (genvar r = 0; r < NUM_STEER; r++) begin : gSteer
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) steerReg[r] <= '0;
      else if (strobes.steerWr[r]) steerReg[r] <= regWdata[STEER_W-1:0];
    end
    assign steerFlat[r*STEER_W +: STEER_W] = steerReg[r];
  end

  // Error latch: rising edge sets, write-one clears, set wins
  assign errClrMask = strobes.errClr ? regWdata[ERR_BITS-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errBits <= '0;
      errPrev <= '0;
    end else begin
      errPrev <= errEvt;
      errBits <= (errBits & ~errClrMask) | (errEvt & ~errPrev);
    end
  end

  assign errIrq = |errBits;

  // Crossbar: every line collects the sources whose field selects it
  assign srcAct = {pciIrq & pciEn, devIrq & devEn};

  for (genvar n = 0; n < CPU_LINES; n++) begin : gLine
    for (genvar s = 0; s < NUM_SRC; s++) begin : gSrc
      assign lineHit[n][s] = srcAct[s] &&
                             (steerFlat[s*SEL_W +: SEL_W] == SEL_W'(n));
    end
    assign cpuIrq[n] = |lineHit[n];
  end

  // Read mux
  always_comb begin
    regRdata = '0;
    unique case (strobes.rdKind)
      RD_DEV: regRdata[DEV_SRCS-1:0] = devIrq;
      RD_ERR: regRdata[ERR_BITS-1:0] = errBits;
      RD_PCI: regRdata[PCI_SRCS-1:0] = pciIrq;
      RD_STEER: begin
        for (int r = 0; r < NUM_STEER; r++) begin
          if (r == int'(strobes.rdIdx)) regRdata[STEER_W-1:0] = steerReg[r];
        end
      end
      default: regRdata = '0;
    endcase
  end

  // R5: with both masks clear, no line can be driven.
  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (devEn == '0 && pciEn == '0) |-> (cpuIrq == '0));

  // R4: an active line needs at least one enabled, asserted source.
  assert_line_has_source_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuIrq != '0) |-> (((devIrq & devEn) != '0) || ((pciIrq & pciEn) != '0)));

  // R6: a latched error bit survives any cycle without a clear write.
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.errClr |=> ((errBits & $past(errBits)) == $past(errBits)));

  // R6/R7: an event edge is always captured, even against a clear.
  for (genvar b = 0; b < ERR_BITS; b++) begin : gErrChk
    assert_err_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
      $rose(errEvt[b]) |=> errBits[b]);
  end

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int PCI_SRCS  = 4,
  parameter int DEV_SRCS  = 8,
  parameter int CPU_LINES = 4,
  parameter int ERR_BITS  = 3,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWe,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  input  logic [DEV_SRCS-1:0]  devIrq,
  input  logic [PCI_SRCS-1:0]  pciIrq,
  input  logic [ERR_BITS-1:0]  errEvt,
  output logic [CPU_LINES-1:0] cpuIrq,
  output logic                 errIrq
);

  localparam int NUM_SRC   = DEV_SRCS + PCI_SRCS;
  localparam int NUM_STEER = (NUM_SRC + STEER_FIELDS - 1) / STEER_FIELDS;

  ctrlStrobes_t strobes;

  irq_route_ctrl #(
    .ADDR_W   (ADDR_W),
    .NUM_STEER(NUM_STEER)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .regAddr(regAddr),
    .regWe  (regWe),
    .strobes(strobes)
  );

  irq_route_dp #(
    .PCI_SRCS (PCI_SRCS),
    .DEV_SRCS (DEV_SRCS),
    .CPU_LINES(CPU_LINES),
    .ERR_BITS (ERR_BITS),
    .DATA_W   (DATA_W),
    .NUM_STEER(NUM_STEER)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .regWdata(regWdata),
    .devIrq  (devIrq),
    .pciIrq  (pciIrq),
    .errEvt  (errEvt),
    .regRdata(regRdata),
    .cpuIrq  (cpuIrq),
    .errIrq  (errIrq)
  );

endmodule

// File: tb/irq_route_top_tb_top.sv
module irq_route_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [7:0]  devIrq = '0;
  logic [3:0]  pciIrq = '0;
  logic [2:0]  errEvt = '0;
  logic [3:0]  cpuIrq;
  logic        errIrq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irq_route_top dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .devIrq(devIrq),
    .pciIrq(pciIrq), .errEvt(errEvt), .cpuIrq(cpuIrq), .errIrq(errIrq)
  );

  // Reference model state
  int devEnM, pciEnM, errM, prevM;
  int steerM [3];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devEnM = 0; pciEnM = 0; errM = 0; prevM = 0;
      for (int i = 0; i < 3; i++) steerM[i] = 0;
    end else begin
      int clr;
      clr = 0;
      if (regWe) begin
        case (regAddr)
          4'd0: devEnM = regWdata & 32'hFF;
          4'd1: clr = regWdata & 32'h7;
          4'd2: pciEnM = regWdata & 32'hF;
          4'd3, 4'd4, 4'd5: steerM[regAddr - 3] = regWdata & 32'hFF;
          default: ;
        endcase
      end
      errM = (errM & ~clr) | (errEvt & ~prevM);
      prevM = errEvt;
    end
  end

  function automatic int expCpu();
    int res = 0;
    for (int s = 0; s < 12; s++) begin
      bit on;
      int line;
      if (s < 8) on = devIrq[s] && devEnM[s];
      else       on = pciIrq[s-8] && pciEnM[s-8];
      line = (steerM[s/4] >> (2*(s%4))) & 3;
      if (on) res = res | (1 << line);
    end
    return res;
  endfunction

  function automatic int expRd();
    case (regAddr)
      4'd0: return int'(devIrq);
      4'd1: return errM;
      4'd2: return int'(pciIrq);
      4'd3, 4'd4, 4'd5: return steerM[regAddr - 3];
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R4 cpuIrq", {28'd0, cpuIrq}, expCpu());
      chk("R8 errIrq", {31'd0, errIrq}, {31'd0, (errM != 0)});
      chk("R2 regRdata", regRdata, expRd());
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #2;
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    @(negedge clk);
    d = regRdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [3:0] cpuSnap;
    idle(3);
    #1 rstN = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 cpuIrq", {28'd0, cpuIrq}, 32'd0);
    chk("R1 errIrq", {31'd0, errIrq}, 32'd0);
    for (int a = 0; a < 16; a++) begin
      rd(a[3:0], v);
      chk("R1 read", v, 32'd0);
    end

    // R5 / R2: inputs high, masks clear
    @(posedge clk); #2;
    devIrq = 8'hFF; pciIrq = 4'hF;
    @(negedge clk);
    chk("R5 masked", {28'd0, cpuIrq}, 32'd0);
    rd(4'd0, v); chk("R2 raw dev", v, 32'hFF);
    rd(4'd2, v); chk("R2 raw pci", v, 32'hF);

    // R4: all device sources to line 0
    wr(4'd0, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R4 all line0", {28'd0, cpuIrq}, 32'h1);

    // R3 steering layout
    wr(4'd3, 32'hE4);
    wr(4'd4, 32'h1B);
    wr(4'd5, 32'hE4);
    rd(4'd3, v); chk("R3 steer0", v, 32'hE4);
    rd(4'd4, v); chk("R3 steer1", v, 32'h1B);
    rd(4'd5, v); chk("R3 steer2", v, 32'hE4);
    @(posedge clk); #2;
    devIrq = 8'h04; pciIrq = 4'h0;
    @(negedge clk);
    chk("R3 keyboard to line2", {28'd0, cpuIrq}, 32'h4);
    @(posedge clk); #2;
    devIrq = 8'h20;
    @(negedge clk);
    chk("R3 parallel to line2", {28'd0, cpuIrq}, 32'h4);
    @(posedge clk); #2;
    devIrq = 8'h80;
    @(negedge clk);
    chk("R3 clock to line0", {28'd0, cpuIrq}, 32'h1);
    @(posedge clk); #2;
    devIrq = 8'h00; pciIrq = 4'h8;
    @(negedge clk);
    chk("R5 pci disabled", {28'd0, cpuIrq}, 32'h0);
    wr(4'd2, 32'hF);
    @(negedge clk);
    chk("R3 pci3 to line3", {28'd0, cpuIrq}, 32'h8);
    @(posedge clk); #2;
    devIrq = 8'h01; pciIrq = 4'h2;
    @(negedge clk);
    chk("R4 two lines", {28'd0, cpuIrq}, 32'h3);

    // R10 write timing
    @(posedge clk); #2;
    regWe = 1'b1; regAddr = 4'd3; regWdata = 32'h55;
    @(negedge clk);
    chk("R10 old value", regRdata, 32'hE4);
    @(posedge clk); #2;
    regWe = 1'b0;
    @(negedge clk);
    chk("R10 new value", regRdata, 32'h55);

    // R9 unmapped write, read side effects
    @(posedge clk); #2;
    cpuSnap = cpuIrq;
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd15, 32'h0);
    rd(4'd9, v); chk("R9 unmapped read", v, 32'd0);
    rd(4'd3, v); chk("R9 steer0 kept", v, 32'h55);
    rd(4'd5, v); chk("R9 steer2 kept", v, 32'hE4);
    chk("R9 cpuIrq kept", {28'd0, cpuIrq}, {28'd0, cpuSnap});

    // R6 / R8 error capture
    @(posedge clk); #2;
    errEvt = 3'b010;
    @(posedge clk); #2;
    errEvt = 3'b000;
    idle(2);
    rd(4'd1, v); chk("R6 power fail sticky", v, 32'h2);
    chk("R8 errIrq", {31'd0, errIrq}, 32'd1);
    idle(2);
    rd(4'd1, v); chk("R9 read keeps errors", v, 32'h2);

    // R7 selective clear and level held high
    @(posedge clk); #2;
    errEvt = 3'b001;
    idle(2);
    wr(4'd1, 32'h4);
    rd(4'd1, v); chk("R7 other bits kept", v, 32'h3);
    wr(4'd1, 32'h1);
    rd(4'd1, v); chk("R7 clear while high", v, 32'h2);
    @(posedge clk); #2;
    errEvt = 3'b000;
    wr(4'd1, 32'h2);
    rd(4'd1, v); chk("R7 cleared", v, 32'h0);
    chk("R8 errIrq low", {31'd0, errIrq}, 32'd0);

    // R7 collision: clear and rising edge together
    @(posedge clk); #2;
    regWe = 1'b1; regAddr = 4'd1; regWdata = 32'h4; errEvt = 3'b100;
    @(posedge clk); #2;
    regWe = 1'b0; errEvt = 3'b000;
    rd(4'd1, v); chk("R7 set wins", v, 32'h4);

    // Random traffic against the model
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); #2;
      devIrq   = 8'($urandom);
      pciIrq   = 4'($urandom);
      errEvt   = 3'($urandom);
      regWe    = (($urandom % 3) == 0);
      regAddr  = 4'($urandom % 8);
      regWdata = $urandom;
    end
    @(posedge clk); #2;
    regWe = 1'b0;
    idle(2);
    finish_run();
  end

endmodule